// File: doc/BRIEF.md
# Quad-Data-Rate Four-Beat Burst SRAM Port

This block models a synchronous memory with a read data bus and a write data bus that are fully separate. The two buses share one address bus. The clock runs at beat rate. Every four beats form a frame: beats 0 and 2 stand for the rising edges of the main input clock, and beats 1 and 3 stand for the rising edges of its complement. A read request is taken from the address bus at beat 0 and a write request at beat 2. Each request moves a burst of four words. Write data arrives one word per beat, and read data leaves one word per beat, so a read burst and a write burst can run at the same time without any bus turnaround.

Read data starts two input-clock cycles (four beats) after the request is taken. A valid flag marks the four beats that carry read data. Writes go through per-byte, active-low write selects. The four words of a write are stored together once the last beat has arrived. The read path takes its copy of the array after any earlier write has been stored, so a read always sees writes that were requested before it, even if their data was still arriving when the read was requested. The array is built from four banks, one per burst position, and both its depth and its byte layout are parameters.

Top module: `qdr_burst_sram`

## Requirements
- R1: One frame can hold both a read request and a write request. The read burst and the write burst then move at the same time on their own buses.
- R2: The beat index is 0 at the first clock edge after reset is released and then counts 0,1,2,3 in a loop. The read address is sampled only at beat 0 and the write address only at beat 2. The address at beats 1 and 3 has no effect.
- R3: A request at address A covers four array words, at index A*4+i for i = 0..3, and they move in order i = 0,1,2,3. Write word i is sampled at the edge i beats after the write request edge, with word 0 sampled at the request edge itself.
- R4: Read word 0 appears on rd_data after the fourth edge following the read request edge. Words 1, 2 and 3 follow on the next three edges.
- R5: rd_valid is 1 during exactly the four beats that carry read words and 0 at all other times. Read bursts requested in back-to-back frames give an unbroken run of valid beats.
- R6: rd_n and wr_n are active low. A high select at its own slot beat starts no burst. A select of either level at any other beat has no effect, and a burst that has already started completes.
- R7: wr_be_n has one bit per byte for each beat. When bit j is low, bits 8j+7..8j of that beat's word are written. When bit j is high, that byte keeps its stored value.
- R8: A read requested one frame after a write to the same address returns the new data, even though the last two write words arrive after the read request.
- R9: A write is stored only after all four of its words have arrived. A read requested at beat 0 of the same frame as a write to the same address returns the data from before that write.
- R10: rst_n is an asynchronous active-low reset. It clears rd_valid at once, drops any read or write burst in progress, and leaves the array contents as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Shared burst address (read at beat 0, write at beat 2) |
| rd_n | input | 1 | Read select, active low, sampled at beat 0 |
| wr_n | input | 1 | Write select, active low, sampled at beat 2 |
| wr_data | input | NBYTES*BYTE_W | Write word for the current beat |
| wr_be_n | input | NBYTES | Active-low byte write selects for the current beat |
| rd_data | output | NBYTES*BYTE_W | Read word for the current beat |
| rd_valid | output | 1 | High on beats that carry read data |

## Verification
If the beat counter slips, every later request is taken at the wrong slot. The first read that follows then shows a wrong rd_valid position or wrong words within four to eight beats. If the read copy is taken at the wrong beat, the coherency cases fail on the very next burst: a read one frame after a write returns stale words, or a read in the same frame as a write returns new words. A fault in the write holding slots or in the byte masks stays hidden in the array until that address is read back, so the bench reads every address back after each kind of write.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  typedef logic [1:0] beat_t;
  localparam int    BURST_LEN   = 4;
  localparam beat_t RD_SLOT     = 2'd0;
  localparam beat_t COMMIT_BEAT = 2'd1;
  localparam beat_t WR_SLOT     = 2'd2;
endpackage

// File: rtl/qdr_beat_seq.sv
module qdr_beat_seq
  import qdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output beat_t beat
);
  beat_t beat_q, beat_nx;

  always_comb beat_nx = beat_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= RD_SLOT;
    else        beat_q <= beat_nx;
  end

  assign beat = beat_q;
endmodule

// File: rtl/qdr_wr_collect.sv
module qdr_wr_collect
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int NBYTES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  beat_t                                beat,
  input  logic                                 wr_n,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic [NBYTES-1:0]                    wr_be_n,
  output logic                                 commit,
  output logic [ADDR_W-1:0]                    commit_addr,
  output logic [BURST_LEN-1:0][DATA_W-1:0]     commit_data,
  output logic [BURST_LEN-1:0][NBYTES-1:0]     commit_be_n
);
  localparam int HOLD = BURST_LEN - 1;

  logic              act_q, act_nx;
  logic              start;
  logic              take;
  beat_t             slot;
  logic [ADDR_W-1:0] addr_q;
  logic [HOLD-1:0][DATA_W-1:0] hold_d;
  logic [HOLD-1:0][NBYTES-1:0] hold_be;

  assign start = (beat == WR_SLOT) && !wr_n;
  assign take  = start || act_q;
  assign slot  = beat + 2'd2;

  always_comb begin
    act_nx = act_q;
    if (beat == WR_SLOT)          act_nx = !wr_n;
    else if (beat == COMMIT_BEAT) act_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_nx;
  end

  always_ff @(posedge clk) begin
    if (start) addr_q <= addr;
  end

  for (genvar i = 0; i < HOLD; i++) begin : g_hold
    logic en;
    assign en = take && (slot == beat_t'(i));
    always_ff @(posedge clk) begin
      if (en) begin
        hold_d[i]  <= wr_data;
        hold_be[i] <= wr_be_n;
      end
    end
    assign commit_data[i] = hold_d[i];
    assign commit_be_n[i] = hold_be[i];
  end

  assign commit_data[HOLD] = wr_data;
  assign commit_be_n[HOLD] = wr_be_n;
  assign commit            = act_q && (beat == COMMIT_BEAT);
  assign commit_addr       = addr_q;
endmodule

// File: rtl/qdr_bank.sv
module qdr_bank #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [NBYTES*BYTE_W-1:0]   wdata,
  input  logic [NBYTES-1:0]          wbe_n,
  input  logic [ADDR_W-1:0]          raddr,
  output logic [NBYTES*BYTE_W-1:0]   rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = NBYTES * BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (!wbe_n[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  beat_t                            beat,
  input  logic                             rd_n,
  input  logic [ADDR_W-1:0]                addr,
  output logic [ADDR_W-1:0]                raddr,
  input  logic [BURST_LEN-1:0][DATA_W-1:0] rwords,
  output logic [DATA_W-1:0]                rd_data,
  output logic                             rd_valid
);
  localparam int TAIL = BURST_LEN - 1;

  logic                             pend_q, pend_nx;
  logic                             stv_q, stv_nx;
  logic [1:0]                       left_q, left_nx;
  logic                             vld_q, vld_nx;
  logic [ADDR_W-1:0]                ra_q, ra_nx;
  logic [BURST_LEN-1:0][DATA_W-1:0] stage_q, stage_nx;
  logic [TAIL-1:0][DATA_W-1:0]      obuf_q, obuf_nx;
  logic [DATA_W-1:0]                dq_q, dq_nx;

  always_comb begin
    pend_nx  = pend_q;
    stv_nx   = stv_q;
    left_nx  = left_q;
    vld_nx   = 1'b0;
    ra_nx    = ra_q;
    stage_nx = stage_q;
    obuf_nx  = obuf_q;
    dq_nx    = dq_q;
    if (beat == RD_SLOT && !rd_n) begin
      pend_nx = 1'b1;
      ra_nx   = addr;
    end
    if (beat == WR_SLOT && pend_q) begin
      stage_nx = rwords;
      stv_nx   = 1'b1;
      pend_nx  = 1'b0;
    end
    if (beat == RD_SLOT && stv_q) begin
      dq_nx   = stage_q[0];
      obuf_nx = stage_q[BURST_LEN-1:1];
      left_nx = 2'(TAIL);
      vld_nx  = 1'b1;
      stv_nx  = 1'b0;
    end else if (left_q != 2'd0) begin
      dq_nx   = obuf_q[0];
      obuf_nx = {{DATA_W{1'b0}}, obuf_q[TAIL-1:1]};
      left_nx = left_q - 2'd1;
      vld_nx  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stv_q  <= 1'b0;
      left_q <= 2'd0;
      vld_q  <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      stv_q  <= stv_nx;
      left_q <= left_nx;
      vld_q  <= vld_nx;
    end
  end

  always_ff @(posedge clk) begin
    ra_q    <= ra_nx;
    stage_q <= stage_nx;
    obuf_q  <= obuf_nx;
    dq_q    <= dq_nx;
  end

  assign raddr    = ra_q;
  assign rd_data  = dq_q;
  assign rd_valid = vld_q;
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NBYTES-1:0] wr_be_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  beat_t                            beat;
  logic                             wr_commit;
  logic [ADDR_W-1:0]                cm_addr;
  logic [BURST_LEN-1:0][DATA_W-1:0] cm_data;
  logic [BURST_LEN-1:0][NBYTES-1:0] cm_be_n;
  logic [ADDR_W-1:0]                rd_addr;
  logic [BURST_LEN-1:0][DATA_W-1:0] rwords;

  qdr_beat_seq u_seq (.clk(clk), .rst_n(rst_n), .beat(beat));

  qdr_wr_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES)) u_wr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .wr_n(wr_n), .addr(addr),
    .wr_data(wr_data), .wr_be_n(wr_be_n), .commit(wr_commit),
    .commit_addr(cm_addr), .commit_data(cm_data), .commit_be_n(cm_be_n)
  );

  for (genvar w = 0; w < BURST_LEN; w++) begin : g_bank
    qdr_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_bank (
      .clk(clk), .we(wr_commit), .waddr(cm_addr), .wdata(cm_data[w]),
      .wbe_n(cm_be_n[w]), .raddr(rd_addr), .rdata(rwords[w])
    );
  end

  qdr_rd_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .beat(beat), .rd_n(rd_n), .addr(addr),
    .raddr(rd_addr), .rwords(rwords), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] beat,
  input logic       rd_n,
  input logic       wr_n,
  input logic       rd_valid,
  input logic       commit
);
  logic [3:0] seen;
  logic       rd_cap, wr_cap;

  assign rd_cap = (beat == 2'd0) && !rd_n;
  assign wr_cap = (beat == 2'd2) && !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               seen <= 4'd0;
    else if (seen != 4'd15)   seen <= seen + 4'd1;
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 4'd0) |-> (beat == 2'($past(beat) + 2'd1)));  // R2

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 4'd5 && $past(rd_cap, 5)) |-> rd_valid);  // R4

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 4'd8 && rd_valid) |->
      ($past(rd_cap, 5) || $past(rd_cap, 6) || $past(rd_cap, 7) || $past(rd_cap, 8)));  // R5

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen < 4'd5) |-> !rd_valid);  // R10

  AST_COMMIT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (seen >= 4'd3 && $past(wr_cap, 3)));  // R6
endmodule

bind qdr_burst_sram qdr_burst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .beat(beat), .rd_n(rd_n), .wr_n(wr_n),
  .rd_valid(rd_valid), .commit(wr_commit)
);

// File: tb/tb_qdr_burst_sram.sv
module tb_qdr_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int NB    = 2;
  localparam int DW    = 16;
  localparam int AW    = 4;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          rd_n, wr_n;
  logic [DW-1:0] wr_data;
  logic [NB-1:0] wr_be_n;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  qdr_burst_sram #(.DEPTH(DEPTH), .BYTE_W(8), .NBYTES(NB)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .wr_data(wr_data), .wr_be_n(wr_be_n), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  string cur_req = "R10";

  // reference model state
  logic [DW-1:0] mmem [DEPTH*4];
  int            n = 0;
  bit            w_act = 0;
  int            w_cnt = 0;
  int            w_addr = 0;
  logic [DW-1:0] w_d [4];
  logic [NB-1:0] w_b [4];
  int            rq_start [$];
  int            rq_addr  [$];
  logic [DW-1:0] exp_q [$];
  bit            exp_v;
  logic [DW-1:0] exp_d;
  logic [1:0][DW-1:0] carry_d;
  logic [1:0][NB-1:0] carry_b;

  task automatic model_edge();
    int beat = n % 4;
    if (beat == 0 && !rd_n) begin
      rq_start.push_back(n + 4);
      rq_addr.push_back(int'(addr));
    end
    if (beat == 2 && !wr_n) begin
      w_act = 1; w_cnt = 0; w_addr = int'(addr);
    end
    if (w_act) begin
      w_d[w_cnt] = wr_data; w_b[w_cnt] = wr_be_n; w_cnt++;
      if (w_cnt == 4) begin
        for (int i = 0; i < 4; i++)
          for (int b = 0; b < NB; b++)
            if (!w_b[i][b]) mmem[w_addr*4+i][b*8 +: 8] = w_d[i][b*8 +: 8];
        w_act = 0;
      end
    end
    if (rq_start.size() > 0 && rq_start[0] == n) begin
      int a = rq_addr[0];
      void'(rq_start.pop_front());
      void'(rq_addr.pop_front());
      for (int i = 0; i < 4; i++) exp_q.push_back(mmem[a*4+i]);
    end
    exp_v = (exp_q.size() > 0);
    if (exp_v) exp_d = exp_q.pop_front();
    n++;
  endtask

  task automatic compare();
    vectors++;
    if (rd_valid !== exp_v) begin
      miscompares++;
      $display("FAIL %s/R5: rd_valid=%0b expected %0b at edge %0d", cur_req, rd_valid, exp_v, n-1);
    end else if (exp_v && rd_data !== exp_d) begin
      miscompares++;
      $display("FAIL %s: rd_data=%h expected %h at edge %0d", cur_req, rd_data, exp_d, n-1);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic rn, input logic wn,
                     input logic [DW-1:0] d, input logic [NB-1:0] be);
    addr = a; rd_n = rn; wr_n = wn; wr_data = d; wr_be_n = be;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic frame(input bit rd, input logic [AW-1:0] ra, input bit wr,
                       input logic [AW-1:0] wa, input logic [3:0][DW-1:0] wd,
                       input logic [3:0][NB-1:0] wb, input bit noise);
    cyc(ra,  !rd,    !noise, carry_d[0], carry_b[0]);
    cyc(~ra, !noise, !noise, carry_d[1], carry_b[1]);
    cyc(wa,  !noise, !wr,    wd[0],      wb[0]);
    cyc(~wa, !noise, !noise, wd[1],      wb[1]);
    carry_d[0] = wd[2]; carry_d[1] = wd[3];
    carry_b[0] = wb[2]; carry_b[1] = wb[3];
  endtask

  function automatic logic [3:0][DW-1:0] pat(input int a, input int k);
    logic [3:0][DW-1:0] p;
    for (int i = 0; i < 4; i++) p[i] = DW'((k << 12) | (a << 4) | (i << 8) | (i + 1));
    return p;
  endfunction

  task automatic idle(input int frames);
    for (int f = 0; f < frames; f++) frame(0, '0, 0, '0, '0, '1, 0);
  endtask

  task automatic do_reset(input int cycles);
    rst_n = 1'b0;
    w_act = 0; rq_start.delete(); rq_addr.delete(); exp_q.delete();
    carry_d = '0; carry_b = '1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      vectors++;
      if (rd_valid !== 1'b0) begin
        miscompares++;
        $display("FAIL R10: rd_valid=%0b expected 0 during reset", rd_valid);
      end
    end
    n = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    addr = '0; rd_n = 1'b1; wr_n = 1'b1; wr_data = '0; wr_be_n = '1;
    carry_d = '0; carry_b = '1;
    @(negedge clk);
    cur_req = "R10";
    do_reset(3);

    cur_req = "R3";
    for (int a = 0; a < DEPTH; a++) frame(0, '0, 1, AW'(a), pat(a, 1), '0, 0);
    idle(1);

    cur_req = "R1";
    for (int a = 0; a < DEPTH; a++) frame(1, AW'(a), 1, AW'(15 - a), pat(15 - a, 2), '0, 0);
    idle(2);

    cur_req = "R6";
    for (int a = 0; a < 4; a++) frame(0, AW'(a), 0, AW'(a), pat(a, 9), '0, 1);
    frame(1, 4'd2, 1, 4'd9, pat(9, 3), '0, 1);
    idle(2);

    cur_req = "R2";
    for (int a = 0; a < DEPTH; a++) frame(1, AW'(a), 0, '0, '0, '1, 0);
    idle(2);

    cur_req = "R7";
    frame(0, '0, 1, 4'd3, pat(3, 5), {2'b10, 2'b01, 2'b11, 2'b00}, 0);
    idle(1);
    frame(1, 4'd3, 0, '0, '0, '1, 0);
    idle(2);

    cur_req = "R8";
    frame(0, '0, 1, 4'd5, pat(5, 6), '0, 0);
    frame(1, 4'd5, 0, '0, '0, '1, 0);
    idle(2);

    cur_req = "R9";
    frame(1, 4'd6, 1, 4'd6, pat(6, 7), '0, 0);
    frame(1, 4'd6, 0, '0, '0, '1, 0);
    idle(2);

    cur_req = "R4";
    for (int a = 0; a < 4; a++) frame(1, AW'(a + 8), 1, AW'(a), pat(a, 4), '0, 0);
    idle(2);

    cur_req = "R10";
    frame(1, 4'd7, 1, 4'd7, pat(7, 8), '0, 0);
    do_reset(2);
    frame(1, 4'd7, 0, '0, '0, '1, 0);
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule